// File: doc/BRIEF.md
# Per-frame RGB histogram accumulator

The block counts how often each 8-bit gray level appears in the red, green and blue channels of a video frame. Pixels arrive as a stream that carries two pixels per clock, one from an even line and one from an odd line, each with its own red, green and blue values. A data-enable qualifies the pixels. A vertical-sync input marks the end of each frame.

Each channel has one counter for every gray level. A one-hot decode of each pixel value selects the counters that step. At the rising edge of vertical sync, every working count is copied into a frozen bank. The working counters then restart for the next frame, and a one-cycle valid pulse tells the consumer that a new histogram can be read. A consumer reads any frozen bin by giving a channel select and a bin index. The read is combinational. The frozen bank changes only at frame ends, so a read never returns a mix of two frames.

Top module: `rgb_frame_hist`

## Requirements
- R1: While rst_ni is low and after it is released, every frozen count reads 0 and frame_valid_o is 0 until the first frame end.
- R2: In a cycle with de_i high, each channel's working bin for the even pixel value and for the odd pixel value advances by one. The channels count independently of each other.
- R3: When the even and odd pixel of a channel carry the same value in one cycle, that bin advances by 2.
- R4: Pixels presented while de_i is low change no count.
- R5: A frame end is a clock edge where vs_i is high and was low at the previous edge. At that edge all working counts are copied to the frozen bank and the working counters clear. frame_valid_o is high for exactly the one following cycle, and from that cycle the reads return the new counts.
- R6: Frozen counts stay unchanged between frame ends, whatever pixels arrive.
- R7: A count stops at 2^CNT_W-1 and never wraps. The default CNT_W of 21 holds a full 1280x1024 frame.
- R8: rd_cnt_o returns the frozen count of bin rd_bin_i in the channel selected by rd_ch_i, where 0 is red, 1 is green and 2 is blue. A select of 3 returns 0.
- R9: Pixels with de_i high in the frame-end cycle are counted into the new frame, not into the frame being frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| de_i | input | 1 | Data enable qualifying both pixels |
| vs_i | input | 1 | Vertical sync; rising edge ends a frame |
| r_even_i | input | 8 | Red value, even-line pixel |
| g_even_i | input | 8 | Green value, even-line pixel |
| b_even_i | input | 8 | Blue value, even-line pixel |
| r_odd_i | input | 8 | Red value, odd-line pixel |
| g_odd_i | input | 8 | Green value, odd-line pixel |
| b_odd_i | input | 8 | Blue value, odd-line pixel |
| rd_ch_i | input | 2 | Read channel select |
| rd_bin_i | input | 8 | Read bin index |
| rd_cnt_o | output | CNT_W | Frozen count of the selected bin |
| frame_valid_o | output | 1 | One-cycle pulse after each frame end |

## Verification
The assertions check the following on every cycle:
- the valid pulse lasts one cycle;
- the pulse follows a vertical-sync rise and occurs only then;
- a read with a steady address returns a steady value between frame ends;
- an unused channel select returns zero.

The per-bin arithmetic needs the bench's reference model, which checks all of these cases:
- single and double increments;
- counting gated by data-enable;
- saturation;
- pixels that arrive in the frame-end cycle.

The model holds its own counts for every bin and checks them by sweeping all frozen bins after each frame.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int unsigned CH_N = 3;
  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2,
    CH_NONE  = 2'd3
  } ch_sel_e;
endpackage

// File: rtl/hist_decode.sv
module hist_decode #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned BINS = 1 << DATA_W
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic              en_i,
  output logic [BINS-1:0]   hot_o
);
  always_comb begin
    hot_o        = '0;
    hot_o[val_i] = en_i;
  end
endmodule

// File: rtl/hist_bin.sv
module hist_bin #(
  parameter int unsigned CNT_W = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_a_i,
  input  logic             hit_b_i,
  input  logic             frame_end_i,
  output logic [CNT_W-1:0] frz_o
);
  localparam logic [CNT_W:0] MAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] work_q, work_d;
  logic [CNT_W:0]   base, sum;
  logic [1:0]       inc;

  always_comb begin
    inc    = {1'b0, hit_a_i} + {1'b0, hit_b_i};
    base   = frame_end_i ? '0 : {1'b0, work_q};
    sum    = base + {{(CNT_W-1){1'b0}}, inc};
    work_d = (sum > MAX) ? MAX[CNT_W-1:0] : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q <= '0;
      frz_o  <= '0;
    end else begin
      work_q <= work_d;
      if (frame_end_i) frz_o <= work_q;
    end
  end
endmodule

// File: rtl/hist_channel.sv
module hist_channel #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 21,
  localparam int unsigned BINS  = 1 << DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              de_i,
  input  logic              frame_end_i,
  input  logic [DATA_W-1:0] even_i,
  input  logic [DATA_W-1:0] odd_i,
  input  logic [DATA_W-1:0] rd_bin_i,
  output logic [CNT_W-1:0]  rd_cnt_o
);
  logic [BINS-1:0]  hot_even, hot_odd;
  logic [CNT_W-1:0] frz [BINS];

  hist_decode #(.DATA_W(DATA_W)) dec_even_i (
    .val_i(even_i), .en_i(de_i), .hot_o(hot_even)
  );
  hist_decode #(.DATA_W(DATA_W)) dec_odd_i (
    .val_i(odd_i), .en_i(de_i), .hot_o(hot_odd)
  );

  for (genvar b = 0; b < BINS; b++) begin : g_bin
    hist_bin #(.CNT_W(CNT_W)) bin_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hit_a_i    (hot_even[b]),
      .hit_b_i    (hot_odd[b]),
      .frame_end_i(frame_end_i),
      .frz_o      (frz[b])
    );
  end

  assign rd_cnt_o = frz[rd_bin_i];
endmodule

// File: rtl/rgb_frame_hist.sv
module rgb_frame_hist
  import hist_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              de_i,
  input  logic              vs_i,
  input  logic [DATA_W-1:0] r_even_i,
  input  logic [DATA_W-1:0] g_even_i,
  input  logic [DATA_W-1:0] b_even_i,
  input  logic [DATA_W-1:0] r_odd_i,
  input  logic [DATA_W-1:0] g_odd_i,
  input  logic [DATA_W-1:0] b_odd_i,
  input  logic [1:0]        rd_ch_i,
  input  logic [DATA_W-1:0] rd_bin_i,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic              frame_valid_o
);
  logic              vs_q;
  logic              frame_end;
  logic [DATA_W-1:0] pix_even [CH_N];
  logic [DATA_W-1:0] pix_odd  [CH_N];
  logic [CNT_W-1:0]  ch_cnt   [CH_N];

  assign frame_end = vs_i & ~vs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q          <= 1'b0;
      frame_valid_o <= 1'b0;
    end else begin
      vs_q          <= vs_i;
      frame_valid_o <= frame_end;
    end
  end

  assign pix_even[0] = r_even_i;
  assign pix_even[1] = g_even_i;
  assign pix_even[2] = b_even_i;
  assign pix_odd[0]  = r_odd_i;
  assign pix_odd[1]  = g_odd_i;
  assign pix_odd[2]  = b_odd_i;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    hist_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) ch_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .de_i       (de_i),
      .frame_end_i(frame_end),
      .even_i     (pix_even[c]),
      .odd_i      (pix_odd[c]),
      .rd_bin_i   (rd_bin_i),
      .rd_cnt_o   (ch_cnt[c])
    );
  end

  always_comb begin
    case (ch_sel_e'(rd_ch_i))
      CH_RED:   rd_cnt_o = ch_cnt[0];
      CH_GREEN: rd_cnt_o = ch_cnt[1];
      CH_BLUE:  rd_cnt_o = ch_cnt[2];
      default:  rd_cnt_o = '0;
    endcase
  end
endmodule

// File: rtl/rgb_frame_hist_chk.sv
module rgb_frame_hist_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vs_i,
  input logic [1:0]        rd_ch_i,
  input logic [DATA_W-1:0] rd_bin_i,
  input logic [CNT_W-1:0]  rd_cnt_o,
  input logic              frame_valid_o
);
  a_r5_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);

  a_r5_valid_after_vs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vs_i) |=> frame_valid_o);

  a_r5_valid_needs_vs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> $past(vs_i));

  a_r6_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_valid_o && $stable(rd_ch_i) && $stable(rd_bin_i)) |-> $stable(rd_cnt_o));

  a_r8_unused_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ch_i == 2'd3) |-> (rd_cnt_o == '0));
endmodule

bind rgb_frame_hist rgb_frame_hist_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .vs_i         (vs_i),
  .rd_ch_i      (rd_ch_i),
  .rd_bin_i     (rd_bin_i),
  .rd_cnt_o     (rd_cnt_o),
  .frame_valid_o(frame_valid_o)
);

// File: tb/rgb_frame_hist_tb_top.sv
`timescale 1ns/1ps
module rgb_frame_hist_tb_top;
  localparam int CNT_W = 7;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic de = 1'b0, vs = 1'b0;
  logic [7:0] pe [3];
  logic [7:0] po [3];
  logic [1:0] rd_ch = '0;
  logic [7:0] rd_bin = '0;
  logic [CNT_W-1:0] rd_cnt;
  logic frame_valid;

  always #4 clk = ~clk;

  rgb_frame_hist #(.DATA_W(8), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .de_i(de), .vs_i(vs),
    .r_even_i(pe[0]), .g_even_i(pe[1]), .b_even_i(pe[2]),
    .r_odd_i(po[0]), .g_odd_i(po[1]), .b_odd_i(po[2]),
    .rd_ch_i(rd_ch), .rd_bin_i(rd_bin),
    .rd_cnt_o(rd_cnt), .frame_valid_o(frame_valid)
  );

  int ref_work [3][256];
  int ref_frz  [3][256];
  bit ref_valid = 0;
  bit vs_prev = 0;
  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  function automatic int sat_add(int a, int b);
    return (a + b > MAXC) ? MAXC : a + b;
  endfunction

  task automatic model_step();
    bit rise;
    rise = vs && !vs_prev;
    ref_valid = rise;
    for (int c = 0; c < 3; c++)
      for (int b = 0; b < 256; b++) begin
        if (rise) begin
          ref_frz[c][b]  = ref_work[c][b];
          ref_work[c][b] = 0;
        end
      end
    if (de)
      for (int c = 0; c < 3; c++) begin
        ref_work[c][pe[c]] = sat_add(ref_work[c][pe[c]], 1);
        ref_work[c][po[c]] = sat_add(ref_work[c][po[c]], 1);
      end
    vs_prev = vs;
  endtask

  task automatic compare();
    int exp_cnt;
    exp_cnt = (rd_ch == 2'd3) ? 0 : ref_frz[rd_ch][rd_bin];
    checks++;
    if (frame_valid !== ref_valid) begin
      errors++;
      $display("FAIL R5 frame_valid act=%0b exp=%0b", frame_valid, ref_valid);
    end
    checks++;
    if (rd_cnt !== exp_cnt[CNT_W-1:0]) begin
      errors++;
      $display("FAIL %s rd_cnt ch=%0d bin=%0d act=%0d exp=%0d", tag, rd_ch, rd_bin, rd_cnt, exp_cnt);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #2;
    compare();
  endtask

  task automatic set_pix(input logic [7:0] e0, o0, e1, o1, e2, o2);
    pe[0] = e0; po[0] = o0; pe[1] = e1; po[1] = o1; pe[2] = e2; po[2] = o2;
  endtask

  task automatic end_frame();
    de = 0;
    vs = 1; tick(); tick(); tick();
    vs = 0; tick();
  endtask

  task automatic sweep();
    de = 0; vs = 0;
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 256; b++) begin
        rd_ch = c[1:0]; rd_bin = b[7:0]; tick();
      end
  endtask

  initial begin
    for (int c = 0; c < 3; c++)
      for (int b = 0; b < 256; b++) begin ref_work[c][b] = 0; ref_frz[c][b] = 0; end
    set_pix(0, 0, 0, 0, 0, 0);
    // R1: reads during and after reset
    repeat (3) @(negedge clk);
    checks++;
    if (frame_valid !== 1'b0 || rd_cnt !== '0) begin
      errors++;
      $display("FAIL R1 reset act=%0b/%0d exp=0/0", frame_valid, rd_cnt);
    end
    @(negedge clk); rst_n = 1;
    #2;
    tag = "R1";
    for (int i = 0; i < 8; i++) begin rd_ch = i[1:0]; rd_bin = 8'(i * 37); tick(); end

    // R2: random frame with de high, separate values per channel
    tag = "R2";
    de = 1;
    for (int i = 0; i < 300; i++) begin
      set_pix(8'($urandom_range(0, 15)), 8'($urandom_range(0, 15)),
              8'($urandom_range(16, 40)), 8'($urandom_range(0, 255)),
              8'($urandom_range(200, 210)), 8'($urandom_range(100, 103)));
      rd_ch = i[1:0]; rd_bin = 8'(i * 7);
      tick();
    end
    end_frame();
    tag = "R8"; sweep();

    // R4: de low pixels ignored, interleaved with gaps
    tag = "R4";
    for (int i = 0; i < 200; i++) begin
      de = (i % 3 == 0);
      set_pix(8'(i), 8'(255 - i), 8'(i / 2), 8'(i % 9), 8'(77), 8'(i % 5));
      rd_ch = i[1:0]; rd_bin = 8'(i);
      tick();
    end
    end_frame(); sweep();

    // R3: even and odd pixels share a bin
    tag = "R3";
    de = 1;
    for (int i = 0; i < 40; i++) begin
      set_pix(8'(i % 4), 8'(i % 4), 8'(9), 8'(9), 8'(250), 8'(251));
      tick();
    end
    end_frame(); sweep();

    // R7: saturation at 2^CNT_W-1
    tag = "R7";
    de = 1;
    for (int i = 0; i < 70; i++) begin
      set_pix(8'd5, 8'd5, 8'd6, 8'd7, 8'd5, 8'd5);
      tick();
    end
    end_frame(); sweep();

    // R9: pixels in the frame-end cycle go to the next frame
    tag = "R9";
    de = 1; set_pix(8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6);
    tick(); tick();
    vs = 1; set_pix(8'd100, 8'd100, 8'd101, 8'd101, 8'd102, 8'd102);
    tick();
    de = 0; tick(); tick();
    vs = 0; tick();
    sweep();
    end_frame();
    // R6: frozen bank stays fixed while a new frame streams in
    tag = "R6";
    de = 1;
    for (int i = 0; i < 150; i++) begin
      set_pix(8'(i), 8'(i + 1), 8'(100), 8'(101), 8'(102), 8'(i % 3));
      rd_ch = (i < 75) ? 2'd0 : 2'd1; rd_bin = (i < 75) ? 8'd100 : 8'd101;
      tick();
    end
    de = 0;
    sweep();
    end_frame(); sweep();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule